// File: doc/BRIEF.md
# SDRAM Bank Activation Timing Guard

This block sits between a command source and the command pins of a four-bank SDRAM. Each cycle it looks at one requested command (open a row, read, write, close a bank, or nothing) together with a bank number, a row and a column. It drives the command onto the pins only when doing so breaks none of the row timing rules. While a rule still blocks the request, it holds the request and drives no-operation cycles.

The guard keeps, for every bank, whether the bank is open and which row is open. It also counts the cycles since the bank was last opened and since it was last closed, and it counts the cycles since any bank was last opened. A read or write can target a bank that is closed, or a bank open on another row. In that case the guard inserts the needed close and open commands itself, and it reports the request as accepted only in the cycle the access goes out. Each bank has a warning output that rises once the bank has stayed open close to the longest allowed time, so the source can schedule a close.

All pin outputs are registered, so every command reaches the pins one cycle after the guard accepts it. The ready output is combinational.

Top module: `sdram_act_guard`

## Requirements
- R1: After reset the pins carry no-operation (cs_n=0, ras_n=1, cas_n=1, we_n=1), sd_ba and sd_addr are 0, all warnings are low, and req_ready is high while req_valid is low.
- R2: A read or write goes to the pins only for an open bank whose open row equals req_row, and only at least TRCD cycles after that bank's open command. A read is encoded cs_n=0, ras_n=1, cas_n=0, we_n=1 and a write as cs_n=0, ras_n=1, cas_n=0, we_n=0. sd_addr carries req_col zero-extended, so bit 10 is low.
- R3: Two open commands to the same bank are at least TRC cycles apart on the pins.
- R4: Open commands to different banks are at least TRRD cycles apart on the pins.
- R5: A close follows its bank's open command by at least TRAS_MIN cycles, and an open follows that bank's close by at least TRP cycles. An open is encoded cs_n=0, ras_n=0, cas_n=1, we_n=1 with sd_addr equal to the row. A close is encoded cs_n=0, ras_n=0, cas_n=1, we_n=0 with sd_addr equal to 0.
- R6: A read or write to a closed bank produces an open command of req_row, followed by the access as soon as TRCD allows. req_ready stays low until the access is issued.
- R7: A read or write to a bank that is open on a different row produces a close, then an open of the new row, then the access, each as early as the timing allows.
- R8: An explicit open request to a bank that is already open produces a close followed by the open of the requested row.
- R9: Reads and writes to open banks with matching rows are accepted on consecutive cycles, whether they go to the same bank or to different banks.
- R10: Request codes are 0 no-operation, 1 open, 2 read, 3 write, 4 close; codes 5 to 7 act as no-operation. At most one command reaches the pins per cycle. req_ready is high exactly in the cycle the final command of a request is issued, and also whenever req_valid is low or the request is a no-operation. Cycles with no request, a no-operation request, or a blocked step drive no-operation.
- R11: A close request to a bank that is not open is accepted at once and puts no command on the pins.
- R12: ras_warn[b] is high while bank b is open and at least TRAS_MAX-WARN_MARGIN cycles have passed since its open command. It is low while the bank is closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A request is present |
| req_cmd | input | 3 | Request code (see R10) |
| req_bank | input | $clog2(NUM_BANKS) | Target bank |
| req_row | input | ROW_W | Row to open, or the row expected to be open for an access |
| req_col | input | COL_W | Starting column of a read or write |
| req_ready | output | 1 | Request completes this cycle |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | $clog2(NUM_BANKS) | Bank address of the issued command |
| sd_addr | output | ROW_W | Row, column or zero, depending on the command |
| ras_warn | output | NUM_BANKS | Per-bank warning that the open time is near its limit |

## Verification
The hardest case to reach from the ports is a situation where a later rule still blocks a command after an earlier rule has been met, for example an open that satisfies the close-to-open delay but not the same-bank open-to-open delay. The stimulus opens a fresh bank, opens a second bank at once so the cross-bank spacing stalls it, and closes the first bank as early as allowed. It then asks to reopen the first bank, so the same-bank cycle time lands one cycle after the close recovery time and decides the issue cycle. A second hard case is the per-bank warning, which needs a bank held open for dozens of idle cycles; the bench counts those cycles from the open command on the pins.

// File: rtl/act_guard_pkg.sv
// Shared types and helpers for the SDRAM bank activation timing guard.
// Assumes the usual SDRAM pin encoding where (cs_n, ras_n, cas_n, we_n)
// selects the command on a rising clock edge.
package act_guard_pkg;

    // Request codes presented by the command source.
    typedef enum logic [2:0] {
        REQ_NOP   = 3'd0,
        REQ_ACT   = 3'd1,
        REQ_READ  = 3'd2,
        REQ_WRITE = 3'd3,
        REQ_PRE   = 3'd4
    } req_cmd_e;

    // Command pin group in the order {cs_n, ras_n, cas_n, we_n}.
    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } pin_cmd_t;

    localparam pin_cmd_t PIN_NOP   = 4'b0111;
    localparam pin_cmd_t PIN_ACT   = 4'b0011;
    localparam pin_cmd_t PIN_READ  = 4'b0101;
    localparam pin_cmd_t PIN_WRITE = 4'b0100;
    localparam pin_cmd_t PIN_PRE   = 4'b0010;

    // Larger of two values, used to size the age counters.
    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/act_guard_age_counter.sv
// Saturating age counter: counts cycles since the last restart.
// Assumes restart_i is a single-cycle event. The counter resets to its
// maximum so that nothing looks recent after reset, and it restarts at 1,
// so a value of k means the event was k cycles ago.
module act_guard_age_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart_i,
    output logic [CNT_W-1:0] age_o
);
    localparam logic [CNT_W-1:0] AGE_MAX = '1;

    // Advance the age, restart on an event, and hold at the ceiling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            age_o <= AGE_MAX;
        end else if (restart_i) begin
            age_o <= CNT_W'(1);
        end else if (age_o != AGE_MAX) begin
            age_o <= age_o + CNT_W'(1);
        end
    end

endmodule

// File: rtl/act_guard_bank_timer.sv
// Per-bank state: open flag, open row, and the ages since the last open and
// close command. From these it derives the timing permissions for one bank.
// Assumes act_i and pre_i are never high together (the arbiter issues one
// command per cycle) and that the counters are wide enough for TRAS_MAX.
module act_guard_bank_timer #(
    parameter int ROW_W    = 13,
    parameter int CNT_W    = 8,
    parameter int TRCD     = 2,
    parameter int TRC      = 8,
    parameter int TRAS_MIN = 5,
    parameter int TRP      = 2,
    parameter int WARN_AT  = 56
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_i,
    input  logic             pre_i,
    input  logic [ROW_W-1:0] row_i,
    output logic             open_o,
    output logic [ROW_W-1:0] row_o,
    output logic             rcd_ok_o,
    output logic             act_ok_o,
    output logic             pre_ok_o,
    output logic             warn_o
);
    localparam logic [CNT_W-1:0] L_TRCD    = CNT_W'(TRCD);
    localparam logic [CNT_W-1:0] L_TRC     = CNT_W'(TRC);
    localparam logic [CNT_W-1:0] L_TRASMIN = CNT_W'(TRAS_MIN);
    localparam logic [CNT_W-1:0] L_TRP     = CNT_W'(TRP);
    localparam logic [CNT_W-1:0] L_WARN    = CNT_W'(WARN_AT);

    logic [CNT_W-1:0] since_act;
    logic [CNT_W-1:0] since_pre;

    act_guard_age_counter #(.CNT_W(CNT_W)) u_act_age (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (act_i),
        .age_o     (since_act)
    );

    act_guard_age_counter #(.CNT_W(CNT_W)) u_pre_age (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (pre_i),
        .age_o     (since_pre)
    );

    // Track whether the bank is open and which row it holds.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_o <= 1'b0;
            row_o  <= '0;
        end else if (act_i) begin
            open_o <= 1'b1;
            row_o  <= row_i;
        end else if (pre_i) begin
            open_o <= 1'b0;
        end
    end

    // Derive the per-bank timing permissions and the long-open warning.
    always_comb begin
        rcd_ok_o = (since_act >= L_TRCD);
        act_ok_o = (since_act >= L_TRC) && (since_pre >= L_TRP);
        pre_ok_o = (since_act >= L_TRASMIN);
        warn_o   = open_o && (since_act >= L_WARN);
    end

endmodule

// File: rtl/act_guard_arbiter.sv
// Combinational decision for one request per cycle. It picks the next pin
// command (close, open, access or nothing) from the bank states and timing
// permissions, and it says whether the request completes this cycle.
// Assumes COL_W <= 10, so a zero-extended column leaves address bit 10 low.
module act_guard_arbiter
    import act_guard_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int BANK_W    = 2,
    parameter int ROW_W     = 13,
    parameter int COL_W     = 9
) (
    input  logic                            req_valid_i,
    input  logic [2:0]                      req_cmd_i,
    input  logic [BANK_W-1:0]               req_bank_i,
    input  logic [ROW_W-1:0]                req_row_i,
    input  logic [COL_W-1:0]                req_col_i,
    input  logic [NUM_BANKS-1:0]            open_i,
    input  logic [NUM_BANKS-1:0][ROW_W-1:0] rows_i,
    input  logic [NUM_BANKS-1:0]            rcd_ok_i,
    input  logic [NUM_BANKS-1:0]            act_ok_i,
    input  logic [NUM_BANKS-1:0]            pre_ok_i,
    input  logic                            rrd_ok_i,
    output logic                            accept_o,
    output logic                            issue_act_o,
    output logic                            issue_pre_o,
    output logic                            issue_rw_o,
    output pin_cmd_t                        pin_o,
    output logic [ROW_W-1:0]                addr_o
);
    req_cmd_e cmd;
    logic     bank_open;
    logic     row_hit;
    logic     can_open;

    assign cmd       = req_cmd_e'(req_cmd_i);
    assign bank_open = open_i[req_bank_i];
    assign row_hit   = (rows_i[req_bank_i] == req_row_i);
    assign can_open  = act_ok_i[req_bank_i] && rrd_ok_i;

    // Choose the single step to issue this cycle and whether the request ends.
    always_comb begin
        accept_o    = 1'b0;
        issue_act_o = 1'b0;
        issue_pre_o = 1'b0;
        issue_rw_o  = 1'b0;
        if (req_valid_i) begin
            unique case (cmd)
                REQ_ACT: begin
                    if (bank_open) begin
                        issue_pre_o = pre_ok_i[req_bank_i];
                    end else if (can_open) begin
                        issue_act_o = 1'b1;
                        accept_o    = 1'b1;
                    end
                end
                REQ_PRE: begin
                    if (!bank_open) begin
                        accept_o = 1'b1;
                    end else if (pre_ok_i[req_bank_i]) begin
                        issue_pre_o = 1'b1;
                        accept_o    = 1'b1;
                    end
                end
                REQ_READ, REQ_WRITE: begin
                    if (bank_open && row_hit) begin
                        if (rcd_ok_i[req_bank_i]) begin
                            issue_rw_o = 1'b1;
                            accept_o   = 1'b1;
                        end
                    end else if (bank_open) begin
                        issue_pre_o = pre_ok_i[req_bank_i];
                    end else begin
                        issue_act_o = can_open;
                    end
                end
                default: accept_o = 1'b1;
            endcase
        end
    end

    // Encode the chosen step onto the command pins and the address bus.
    always_comb begin
        pin_o  = PIN_NOP;
        addr_o = '0;
        if (issue_act_o) begin
            pin_o  = PIN_ACT;
            addr_o = req_row_i;
        end else if (issue_pre_o) begin
            pin_o  = PIN_PRE;
        end else if (issue_rw_o) begin
            pin_o  = (cmd == REQ_WRITE) ? PIN_WRITE : PIN_READ;
            addr_o = ROW_W'(req_col_i);
        end
    end

endmodule

// File: rtl/sdram_act_guard.sv
// SDRAM bank activation timing guard (top). It holds one timer set per bank,
// an age counter for cross-bank open spacing, and the arbiter, and it
// registers the chosen command onto the pins. Assumes the request source
// keeps a request stable until req_ready is seen high at a clock edge.
module sdram_act_guard
    import act_guard_pkg::*;
#(
    parameter int NUM_BANKS   = 4,
    parameter int ROW_W       = 13,
    parameter int COL_W       = 9,
    parameter int TRCD        = 2,
    parameter int TRP         = 2,
    parameter int TRAS_MIN    = 5,
    parameter int TRC         = 8,
    parameter int TRRD        = 2,
    parameter int TRAS_MAX    = 64,
    parameter int WARN_MARGIN = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_valid,
    input  logic [2:0]                   req_cmd,
    input  logic [$clog2(NUM_BANKS)-1:0] req_bank,
    input  logic [ROW_W-1:0]             req_row,
    input  logic [COL_W-1:0]             req_col,
    output logic                         req_ready,
    output logic                         sd_cs_n,
    output logic                         sd_ras_n,
    output logic                         sd_cas_n,
    output logic                         sd_we_n,
    output logic [$clog2(NUM_BANKS)-1:0] sd_ba,
    output logic [ROW_W-1:0]             sd_addr,
    output logic [NUM_BANKS-1:0]         ras_warn
);
    localparam int BANK_W  = $clog2(NUM_BANKS);
    localparam int CNT_W   = $clog2(max2(TRAS_MAX, TRC) + 2);
    localparam int WARN_AT = TRAS_MAX - WARN_MARGIN;
    localparam logic [CNT_W-1:0] L_TRRD = CNT_W'(TRRD);

    logic [NUM_BANKS-1:0]            bank_open;
    logic [NUM_BANKS-1:0][ROW_W-1:0] bank_row;
    logic [NUM_BANKS-1:0]            rcd_ok;
    logic [NUM_BANKS-1:0]            act_ok;
    logic [NUM_BANKS-1:0]            pre_ok;
    logic [CNT_W-1:0]                since_any_act;
    logic                            rrd_ok;
    logic                            accept;
    logic                            issue_act;
    logic                            issue_pre;
    logic                            issue_rw;
    pin_cmd_t                        pin_nxt;
    pin_cmd_t                        pin_q;
    logic [ROW_W-1:0]                addr_nxt;

    // One timer set per bank; only the addressed bank sees the issue strobes.
    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        logic hit;
        assign hit = (req_bank == BANK_W'(g));

        act_guard_bank_timer #(
            .ROW_W    (ROW_W),
            .CNT_W    (CNT_W),
            .TRCD     (TRCD),
            .TRC      (TRC),
            .TRAS_MIN (TRAS_MIN),
            .TRP      (TRP),
            .WARN_AT  (WARN_AT)
        ) u_timer (
            .clk      (clk),
            .rst_n    (rst_n),
            .act_i    (issue_act && hit),
            .pre_i    (issue_pre && hit),
            .row_i    (req_row),
            .open_o   (bank_open[g]),
            .row_o    (bank_row[g]),
            .rcd_ok_o (rcd_ok[g]),
            .act_ok_o (act_ok[g]),
            .pre_ok_o (pre_ok[g]),
            .warn_o   (ras_warn[g])
        );
    end

    act_guard_age_counter #(.CNT_W(CNT_W)) u_rrd_age (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (issue_act),
        .age_o     (since_any_act)
    );

    assign rrd_ok = (since_any_act >= L_TRRD);

    act_guard_arbiter #(
        .NUM_BANKS (NUM_BANKS),
        .BANK_W    (BANK_W),
        .ROW_W     (ROW_W),
        .COL_W     (COL_W)
    ) u_arb (
        .req_valid_i (req_valid),
        .req_cmd_i   (req_cmd),
        .req_bank_i  (req_bank),
        .req_row_i   (req_row),
        .req_col_i   (req_col),
        .open_i      (bank_open),
        .rows_i      (bank_row),
        .rcd_ok_i    (rcd_ok),
        .act_ok_i    (act_ok),
        .pre_ok_i    (pre_ok),
        .rrd_ok_i    (rrd_ok),
        .accept_o    (accept),
        .issue_act_o (issue_act),
        .issue_pre_o (issue_pre),
        .issue_rw_o  (issue_rw),
        .pin_o       (pin_nxt),
        .addr_o      (addr_nxt)
    );

    // The request completes when accepted; an empty slot is always ready.
    assign req_ready = !req_valid || accept;

    // Register the chosen command, bank and address onto the pins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_q   <= PIN_NOP;
            sd_ba   <= '0;
            sd_addr <= '0;
        end else begin
            pin_q   <= pin_nxt;
            sd_ba   <= (issue_act || issue_pre || issue_rw) ? req_bank : '0;
            sd_addr <= addr_nxt;
        end
    end

    assign sd_cs_n  = pin_q.cs_n;
    assign sd_ras_n = pin_q.ras_n;
    assign sd_cas_n = pin_q.cas_n;
    assign sd_we_n  = pin_q.we_n;

endmodule

// File: rtl/act_guard_checker.sv
// Pin-level timing checker for sdram_act_guard. It rebuilds bank ages and
// open flags only from the observed pins, then checks the spacing rules.
// Assumes TRRD, TRCD and the warning threshold are all at least 1.
module act_guard_checker
    import act_guard_pkg::*;
#(
    parameter int NUM_BANKS   = 4,
    parameter int ROW_W       = 13,
    parameter int TRCD        = 2,
    parameter int TRP         = 2,
    parameter int TRAS_MIN    = 5,
    parameter int TRC         = 8,
    parameter int TRRD        = 2,
    parameter int TRAS_MAX    = 64
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         req_valid,
    input logic                         req_ready,
    input logic                         sd_cs_n,
    input logic                         sd_ras_n,
    input logic                         sd_cas_n,
    input logic                         sd_we_n,
    input logic [$clog2(NUM_BANKS)-1:0] sd_ba,
    input logic [ROW_W-1:0]             sd_addr,
    input logic [NUM_BANKS-1:0]         ras_warn
);
    localparam int CW = $clog2(max2(TRAS_MAX, TRC) + 2);
    localparam logic [CW-1:0] CMAX = '1;

    pin_cmd_t pins;
    logic     p_act;
    logic     p_pre;
    logic     p_rw;
    logic     p_nop;
    logic [CW-1:0] a_age [NUM_BANKS];
    logic [CW-1:0] p_age [NUM_BANKS];
    logic [CW-1:0] any_age;
    logic [NUM_BANKS-1:0] seen_open;

    assign pins  = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    assign p_act = (pins == PIN_ACT);
    assign p_pre = (pins == PIN_PRE);
    assign p_rw  = (pins == PIN_READ) || (pins == PIN_WRITE);
    assign p_nop = (pins == PIN_NOP);

    // Rebuild per-bank ages and open flags from the observed pin commands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            any_age   <= CMAX;
            seen_open <= '0;
            for (int b = 0; b < NUM_BANKS; b++) begin
                a_age[b] <= CMAX;
                p_age[b] <= CMAX;
            end
        end else begin
            any_age <= p_act ? CW'(1) : ((any_age == CMAX) ? CMAX : any_age + CW'(1));
            for (int b = 0; b < NUM_BANKS; b++) begin
                if (p_act && sd_ba == b[$clog2(NUM_BANKS)-1:0]) begin
                    a_age[b]     <= CW'(1);
                    seen_open[b] <= 1'b1;
                end else if (a_age[b] != CMAX) begin
                    a_age[b] <= a_age[b] + CW'(1);
                end
                if (p_pre && sd_ba == b[$clog2(NUM_BANKS)-1:0]) begin
                    p_age[b]     <= CW'(1);
                    seen_open[b] <= 1'b0;
                end else if (p_age[b] != CMAX) begin
                    p_age[b] <= p_age[b] + CW'(1);
                end
            end
        end
    end

    a_r2_access_after_rcd: assert property (@(posedge clk) disable iff (!rst_n)
        p_rw |-> (seen_open[sd_ba] && a_age[sd_ba] >= CW'(TRCD)));

    a_r3_same_bank_rc: assert property (@(posedge clk) disable iff (!rst_n)
        p_act |-> (a_age[sd_ba] >= CW'(TRC)));

    a_r4_cross_bank_rrd: assert property (@(posedge clk) disable iff (!rst_n)
        p_act |-> (any_age >= CW'(TRRD)));

    a_r5_close_after_ras_min: assert property (@(posedge clk) disable iff (!rst_n)
        p_pre |-> (a_age[sd_ba] >= CW'(TRAS_MIN)));

    a_r5_open_after_rp: assert property (@(posedge clk) disable iff (!rst_n)
        p_act |-> (p_age[sd_ba] >= CW'(TRP)));

    a_r10_idle_gives_nop: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> p_nop);

    a_r10_idle_is_ready: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> req_ready);

    a_r5_close_addr_zero: assert property (@(posedge clk) disable iff (!rst_n)
        p_pre |-> (sd_addr == '0));

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_warn
        a_r12_no_warn_closed: assert property (@(posedge clk) disable iff (!rst_n)
            (!seen_open[g] && !p_act) |-> !ras_warn[g]);
    end

endmodule

bind sdram_act_guard act_guard_checker #(
    .NUM_BANKS (NUM_BANKS),
    .ROW_W     (ROW_W),
    .TRCD      (TRCD),
    .TRP       (TRP),
    .TRAS_MIN  (TRAS_MIN),
    .TRC       (TRC),
    .TRRD      (TRRD),
    .TRAS_MAX  (TRAS_MAX)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .sd_cs_n   (sd_cs_n),
    .sd_ras_n  (sd_ras_n),
    .sd_cas_n  (sd_cas_n),
    .sd_we_n   (sd_we_n),
    .sd_ba     (sd_ba),
    .sd_addr   (sd_addr),
    .ras_warn  (ras_warn)
);

// File: tb/sdram_act_guard_test.sv
module sdram_act_guard_test;
    localparam int CLK_PERIOD = 10;

    localparam logic [3:0] P_NOP = 4'b0111;
    localparam logic [3:0] P_ACT = 4'b0011;
    localparam logic [3:0] P_RD  = 4'b0101;
    localparam logic [3:0] P_WR  = 4'b0100;
    localparam logic [3:0] P_PRE = 4'b0010;

    localparam logic [2:0] C_NOP = 3'd0;
    localparam logic [2:0] C_ACT = 3'd1;
    localparam logic [2:0] C_RD  = 3'd2;
    localparam logic [2:0] C_WR  = 3'd3;
    localparam logic [2:0] C_PRE = 3'd4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_cmd = 3'd0;
    logic [1:0]  req_bank = 2'd0;
    logic [12:0] req_row = 13'd0;
    logic [8:0]  req_col = 9'd0;
    logic        req_ready;
    logic        sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [1:0]  sd_ba;
    logic [12:0] sd_addr;
    logic [3:0]  ras_warn;

    sdram_act_guard uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
        .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
        .req_ready(req_ready), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
        .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba),
        .sd_addr(sd_addr), .ras_warn(ras_warn)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        logic [3:0]  pins;
        logic [1:0]  ba;
        logic [12:0] addr;
        int          gap;
        string       tag;
    } exp_t;

    exp_t sb[$];
    int   n_checks = 0;
    int   n_fail = 0;
    int   cyc = 0;
    int   last_pin_cyc = 0;
    bit   done = 1'b0;

    task automatic check(input bit ok, input string rq, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: every non-idle pin command is compared with the scoreboard head.
    always @(negedge clk) begin
        if (rst_n) begin
            logic [3:0] p;
            p = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
            if (p != P_NOP) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R10", "unexpected pin command", p, P_NOP);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(p == e.pins, e.tag, "pin command", p, e.pins);
                    check(sd_ba == e.ba, e.tag, "bank", sd_ba, e.ba);
                    check(sd_addr == e.addr, e.tag, "address", sd_addr, e.addr);
                    if (e.gap >= 0)
                        check(cyc - last_pin_cyc == e.gap, e.tag, "cycle gap",
                              cyc - last_pin_cyc, e.gap);
                end
                last_pin_cyc = cyc;
            end
        end
    end

    task automatic expect_cmd(input logic [3:0] pins, input logic [1:0] ba,
                              input logic [12:0] addr, input int gap, input string tag);
        exp_t e;
        e.pins = pins; e.ba = ba; e.addr = addr; e.gap = gap; e.tag = tag;
        sb.push_back(e);
    endtask

    // Driver: present a request and hold it until req_ready is seen high.
    task automatic send(input logic [2:0] cmd, input logic [1:0] bank,
                        input logic [12:0] row, input logic [8:0] col,
                        input int exp_stalls, input string tag);
        int stalls;
        @(negedge clk);
        req_valid = 1'b1; req_cmd = cmd; req_bank = bank; req_row = row; req_col = col;
        stalls = 0;
        forever begin
            #1;
            if (req_ready) break;
            stalls++;
            @(negedge clk);
        end
        @(posedge clk);
        #1 req_valid = 1'b0;
        check(stalls == exp_stalls, tag, "stall cycles", stalls, exp_stalls);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == P_NOP, "R1", "reset pins",
              {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, P_NOP);
        check(sd_ba == 0 && sd_addr == 0, "R1", "reset ba/addr", sd_addr, 0);
        check(ras_warn == 0, "R1", "reset warnings", ras_warn, 0);
        check(req_ready == 1'b1, "R1", "idle ready", req_ready, 1);
        rst_n = 1'b1;
        idle(2);

        // R6 / R2: read to a closed bank opens the row, then reads after TRCD
        expect_cmd(P_ACT, 2'd0, 13'd5, -1, "R6");
        expect_cmd(P_RD,  2'd0, 13'd3,  2, "R2");
        send(C_RD, 2'd0, 13'd5, 9'd3, 2, "R6");
        // R9: back-to-back write, same bank
        expect_cmd(P_WR, 2'd0, 13'd4, 1, "R9");
        send(C_WR, 2'd0, 13'd5, 9'd4, 0, "R9");
        // R6: second bank opened by a read
        expect_cmd(P_ACT, 2'd1, 13'd9, 1, "R6");
        expect_cmd(P_RD,  2'd1, 13'd7, 2, "R2");
        send(C_RD, 2'd1, 13'd9, 9'd7, 2, "R6");
        // R9: back-to-back accesses across banks
        expect_cmd(P_WR, 2'd0, 13'd8, 1, "R9");
        send(C_WR, 2'd0, 13'd5, 9'd8, 0, "R9");
        expect_cmd(P_RD, 2'd1, 13'd2, 1, "R9");
        send(C_RD, 2'd1, 13'd9, 9'd2, 0, "R9");
        // R7: row miss splits into close, open, access
        expect_cmd(P_PRE, 2'd0, 13'd0, 1, "R7");
        expect_cmd(P_ACT, 2'd0, 13'd6, 2, "R7");
        expect_cmd(P_RD,  2'd0, 13'd1, 2, "R7");
        send(C_RD, 2'd0, 13'd6, 9'd1, 4, "R7");

        // R11: close to a bank that is not open
        send(C_PRE, 2'd3, 13'd0, 9'd0, 0, "R11");
        @(negedge clk);
        check({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == P_NOP, "R11", "no pin command",
              {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, P_NOP);
        // R10: explicit no-operation and an unused code
        send(C_NOP, 2'd2, 13'd0, 9'd0, 0, "R10");
        send(3'd6, 2'd2, 13'd0, 9'd0, 0, "R10");
        @(negedge clk);
        check({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == P_NOP, "R10", "nop request pins",
              {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, P_NOP);
        idle(12);

        // R4 / R5 / R3: cross-bank spacing, ras min, then row cycle decides
        expect_cmd(P_ACT, 2'd2, 13'd100, -1, "R5");
        send(C_ACT, 2'd2, 13'd100, 9'd0, 0, "R5");
        expect_cmd(P_ACT, 2'd3, 13'd200, 2, "R4");
        send(C_ACT, 2'd3, 13'd200, 9'd0, 1, "R4");
        expect_cmd(P_PRE, 2'd2, 13'd0, 3, "R5");
        send(C_PRE, 2'd2, 13'd0, 9'd0, 2, "R5");
        expect_cmd(P_ACT, 2'd2, 13'd101, 3, "R3");
        send(C_ACT, 2'd2, 13'd101, 9'd0, 2, "R3");
        idle(10);

        // R8: open request to an already open bank
        expect_cmd(P_PRE, 2'd1, 13'd0, -1, "R8");
        expect_cmd(P_ACT, 2'd1, 13'd30, 2, "R8");
        send(C_ACT, 2'd1, 13'd30, 9'd0, 2, "R8");
        // R12: warning rises exactly at TRAS_MAX-WARN_MARGIN = 56 cycles
        for (int k = 1; k <= 56; k++) begin
            @(negedge clk);
            if (k == 55) check(ras_warn[1] == 1'b0, "R12", "warn before threshold", ras_warn[1], 0);
            if (k == 56) check(ras_warn[1] == 1'b1, "R12", "warn at threshold", ras_warn[1], 1);
        end
        expect_cmd(P_PRE, 2'd1, 13'd0, -1, "R12");
        send(C_PRE, 2'd1, 13'd0, 9'd0, 0, "R12");
        @(negedge clk);
        check(ras_warn[1] == 1'b0, "R12", "warn after close", ras_warn[1], 0);

        idle(4);
        check(sb.size() == 0, "R10", "all expected commands issued", sb.size(), 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule